// File: doc/BRIEF.md
# Four-Stage Floating-Point Adder Pipeline

This block adds two floating-point operands in four registered stages. It can accept a new operand pair on every clock cycle. Each operand has three parts: a sign bit, a biased exponent, and a normalized mantissa with an implied leading one. Each stage does one step of the add:

1. Compare the exponents and order the operands by magnitude.
2. Shift the smaller operand's mantissa right to align it.
3. Add or subtract the mantissas.
4. Normalize the result back to the hidden-bit form.

A valid bit travels with every operation. The result comes out together with its own valid flag, exactly four clock edges after the operands were taken in.

The exponent and mantissa widths are parameters. The defaults give a 32-bit word of single-precision shape. Rounding is by truncation only. The block does not handle infinities, NaNs, denormal operands or exception flags. A result whose exponent would reach zero or go below it is flushed to zero.

Top module: `fp_add_pipe4`

## Requirements
- R1: An operand word holds the sign in its MSB, then an EXP_W-bit exponent, then an MAN_W-bit mantissa fraction in the low bits. Each operand's value is (-1)^sign × 1.fraction × 2^(exponent − bias). When `in_valid` is high at a rising edge, `out_valid` is high after exactly the fourth following rising edge, with that operation's result on `out_sum`. If `in_valid` is low, `out_valid` is low four edges later.
- R2: Operations issued on consecutive cycles leave in the same order, one per cycle, with no bubbles and no interaction between them.
- R3: When the signs agree, the result takes that sign. If the mantissa sum reaches 2.0, it is shifted right by one, the exponent rises by one, and the dropped bit is discarded.
- R4: When the signs differ, the smaller magnitude is subtracted from the larger. The result takes the sign of the larger-magnitude operand, whichever input port that operand arrived on.
- R5: The mantissa of the smaller operand is shifted right by the exponent difference, and bits shifted out are truncated. If the difference exceeds MAN_W, that operand contributes nothing.
- R6: If the difference has leading zeros below the hidden-bit position, it is shifted left until its leading one sits in the hidden position. The exponent is reduced by the same count.
- R7: A zero mantissa sum gives an all-zero result word. So does a normalization that would bring the exponent to zero or below. The exponent field is zero in no other result.
- R8: While `rst_n` is low, and on the first cycles after reset until an operation has crossed all four stages, `out_valid` is low.
- R9: With equal exponents, magnitude order is decided by the mantissa fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 1+EXP_W+MAN_W | First operand |
| in_b | input | 1+EXP_W+MAN_W | Second operand |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | 1+EXP_W+MAN_W | Sum of the operation issued four edges earlier |

## Verification
In a full stream, the normalize stage can be shifting one operation's mantissa left by many places in the same cycle as the compare stage swaps the operands of a new pair. This matters because the ordering decision of one operation and the normalization of another then happen side by side. The streaming test provokes this by issuing operations back to back with no gaps. It mixes sign-cancelling pairs, overflowing same-sign pairs and swapped-magnitude pairs. Each output cycle is judged against its own slot, so a stage that holds, skips or mixes data between neighbours shows up as a wrong value or a shifted valid pattern.

// File: rtl/fp_add_pipe4.sv
module fp_add_pipe4 #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [EXP_W+MAN_W:0]   in_a,
  input  logic [EXP_W+MAN_W:0]   in_b,
  output logic                   out_valid,
  output logic [EXP_W+MAN_W:0]   out_sum
);
  localparam int W   = 1 + EXP_W + MAN_W;
  localparam int LZW = $clog2(MAN_W + 2);

  // stage 1: exponent compare and operand ordering
  logic             a_ge;
  logic [W-1:0]     big, sml;
  assign a_ge = in_a[W-2:0] >= in_b[W-2:0];
  assign big  = a_ge ? in_a : in_b;
  assign sml  = a_ge ? in_b : in_a;

  logic             v1, s1_sign, s1_sub;
  logic [EXP_W-1:0] s1_exp, s1_diff;
  logic [MAN_W:0]   s1_mb, s1_ms;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_valid;

  always_ff @(posedge clk) begin
    s1_sign <= big[W-1];
    s1_sub  <= big[W-1] ^ sml[W-1];
    s1_exp  <= big[W-2:MAN_W];
    s1_diff <= big[W-2:MAN_W] - sml[W-2:MAN_W];
    s1_mb   <= {1'b1, big[MAN_W-1:0]};
    s1_ms   <= {1'b1, sml[MAN_W-1:0]};
  end

  // stage 2: mantissa alignment
  logic [MAN_W:0]   al;
  assign al = (s1_diff > EXP_W'(MAN_W)) ? '0 : (s1_ms >> s1_diff);

  logic             v2, s2_sign, s2_sub;
  logic [EXP_W-1:0] s2_exp;
  logic [MAN_W:0]   s2_mb, s2_al;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;

  always_ff @(posedge clk) begin
    s2_sign <= s1_sign;
    s2_sub  <= s1_sub;
    s2_exp  <= s1_exp;
    s2_mb   <= s1_mb;
    s2_al   <= al;
  end

  // stage 3: mantissa add or subtract
  logic             v3, s3_sign;
  logic [EXP_W-1:0] s3_exp;
  logic [MAN_W+1:0] s3_sum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v3 <= 1'b0;
    else        v3 <= v2;

  always_ff @(posedge clk) begin
    s3_sign <= s2_sign;
    s3_exp  <= s2_exp;
    s3_sum  <= s2_sub ? ({1'b0, s2_mb} - {1'b0, s2_al})
                      : ({1'b0, s2_mb} + {1'b0, s2_al});
  end

  // stage 4: normalization
  logic [LZW-1:0]   lz;
  logic             seen;
  always_comb begin
    lz   = '0;
    seen = 1'b0;
    for (int i = MAN_W; i >= 0; i--) begin
      if (s3_sum[i]) seen = 1'b1;
      else if (!seen) lz = lz + 1'b1;
    end
  end

  logic [MAN_W-1:0] norm;
  logic             under;
  logic [W-1:0]     res;
  assign norm  = s3_sum[MAN_W-1:0] << lz;
  assign under = ({{LZW{1'b0}}, s3_exp} <= {{EXP_W{1'b0}}, lz});

  always_comb begin
    if (s3_sum[MAN_W+1])
      res = {s3_sign, s3_exp + 1'b1, s3_sum[MAN_W:1]};
    else if (s3_sum == '0 || under)
      res = '0;
    else
      res = {s3_sign, s3_exp - EXP_W'(lz), norm};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= v3;

  always_ff @(posedge clk) out_sum <= res;
endmodule

// File: rtl/fp_add_pipe4_chk.sv
module fp_add_pipe4_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [EXP_W+MAN_W:0] in_a,
  input logic [EXP_W+MAN_W:0] in_b,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] out_sum
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [3:0]       vq, cq, sq, gq;
  logic [EXP_W-1:0] eq [4];
  logic [EXP_W-1:0] emax, oexp;

  assign emax = (in_a[W-2:MAN_W] > in_b[W-2:MAN_W]) ? in_a[W-2:MAN_W] : in_b[W-2:MAN_W];
  assign oexp = out_sum[W-2:MAN_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vq <= '0; cq <= '0; sq <= '0; gq <= '0;
      for (int i = 0; i < 4; i++) eq[i] <= '0;
    end else begin
      vq <= {vq[2:0], in_valid};
      cq <= {cq[2:0], in_a == {~in_b[W-1], in_b[W-2:0]}};
      sq <= {sq[2:0], in_a[W-1] == in_b[W-1]};
      gq <= {gq[2:0], in_a[W-1]};
      eq[0] <= emax;
      for (int i = 1; i < 4; i++) eq[i] <= eq[i-1];
    end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vq[3]);                                                    // R1
  AST_CANCEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && vq[3] && cq[3] |-> out_sum == '0);                         // R7
  AST_SAME_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && vq[3] && sq[3] |-> out_sum[W-1] == gq[3]);                 // R3
  AST_SAME_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && vq[3] && sq[3] |-> (oexp == eq[3] || oexp == eq[3] + 1'b1)); // R3
  AST_ZERO_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && oexp == '0 |-> out_sum == '0);                             // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> !out_valid);                                                 // R8
endmodule

bind fp_add_pipe4 fp_add_pipe4_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/tb_fp_add_pipe4.sv
`timescale 1ns/1ps
module tb_fp_add_pipe4;
  localparam int EW = 8;
  localparam int MW = 23;
  localparam int W  = 1 + EW + MW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic [W-1:0] out_sum;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_add_pipe4 #(.EXP_W(EW), .MAN_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] bg, sm;
    longint mb, ms, al, s, d;
    int lz, eb;
    if (a[W-2:0] >= b[W-2:0]) begin bg = a; sm = b; end
    else begin bg = b; sm = a; end
    eb = int'(bg[W-2:MW]);
    d  = longint'(bg[W-2:MW]) - longint'(sm[W-2:MW]);
    mb = (longint'(1) << MW) | longint'(bg[MW-1:0]);
    ms = (longint'(1) << MW) | longint'(sm[MW-1:0]);
    al = (d > MW) ? 0 : (ms >> d);
    s  = (bg[W-1] != sm[W-1]) ? mb - al : mb + al;
    if (s == 0) return '0;
    if (s >= (longint'(1) << (MW + 1)))
      return {bg[W-1], EW'(eb + 1), MW'(s >> 1)};
    lz = 0;
    while (s < (longint'(1) << MW)) begin s = s << 1; lz++; end
    if (eb <= lz) return '0;
    return {bg[W-1], EW'(eb - lz), MW'(s)};
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b1, req, {31'b0, out_valid}, 1);
    check(out_sum === exp, req, out_sum, exp);
  endtask

  task automatic t_reset();
    check(out_valid === 1'b0, "R8", {31'b0, out_valid}, 0);
    @(negedge clk);
    in_valid = 1'b1; in_a = 32'h3F800000; in_b = 32'h3F800000;
    @(negedge clk);
    check(out_valid === 1'b0, "R8", {31'b0, out_valid}, 0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    repeat (6) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R8", {31'b0, out_valid}, 0);
    end
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1'b1; in_a = 32'h3F800000; in_b = 32'h40000000;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === (k == 4), "R1", {31'b0, out_valid}, {31'b0, k == 4});
      if (k == 4) check(out_sum === 32'h40400000, "R1", out_sum, 32'h40400000);
    end
  endtask

  task automatic t_same_sign();
    run_op(32'h3F800000, 32'h3F800000, 32'h40000000, "R3");
    run_op(32'h3FC00000, 32'h3FC00000, 32'h40400000, "R3");
    run_op(32'hBF800000, 32'hC0000000, 32'hC0400000, "R3");
    run_op(32'h3F800001, 32'h3F800000, 32'h40000000, "R3");
  endtask

  task automatic t_opp_sign();
    run_op(32'h3F800000, 32'hC0400000, 32'hC0000000, "R4");
    run_op(32'hBF800000, 32'h40400000, 32'h40000000, "R4");
    run_op(32'h3FC00000, 32'hBFE00000, 32'hBE800000, "R9");
    run_op(32'hBFE00000, 32'h3FC00000, 32'hBE800000, "R9");
  endtask

  task automatic t_align();
    run_op(32'h3F800000, 32'h34000000, 32'h3F800001, "R5");
    run_op(32'h34400000, 32'h3F800000, 32'h3F800001, "R5");
    run_op(32'h3F800000, 32'h33800000, 32'h3F800000, "R5");
    run_op(32'h3F800000, 32'hB0800000, 32'h3F800000, "R5");
  endtask

  task automatic t_norm();
    run_op(32'h40000000, 32'hBFC00000, 32'h3F000000, "R6");
    run_op(32'h3F800001, 32'hBF800000, 32'h34000000, "R6");
    run_op(32'h40400000, 32'hC0000000, 32'h3F800000, "R6");
    run_op(32'h01400000, 32'h81000000, 32'h00800000, "R6");
  endtask

  task automatic t_zero();
    run_op(32'h3F800000, 32'hBF800000, 32'h00000000, "R7");
    run_op(32'hC0400000, 32'h40400000, 32'h00000000, "R7");
    run_op(32'h00C00000, 32'h80800000, 32'h00000000, "R7");
  endtask

  task automatic t_stream(input bit gaps);
    logic [W-1:0] ea [48];
    bit           ev [48];
    for (int c = 0; c < 48 + 4; c++) begin
      @(negedge clk);
      if (c >= 4) begin
        check(out_valid === ev[c-4], "R2", {31'b0, out_valid}, {31'b0, ev[c-4]});
        if (ev[c-4]) check(out_sum === ea[c-4], "R2", out_sum, ea[c-4]);
      end
      if (c < 48) begin
        logic [W-1:0] a, b;
        a = {1'($urandom), EW'(60 + $urandom_range(0, 120)), MW'($urandom)};
        case (c % 4)
          0: b = {~a[W-1], a[W-2:0]};
          1: b = {a[W-1], a[W-2:MW], MW'($urandom)};
          2: b = {~a[W-1], a[W-2:MW] - EW'($urandom_range(0, 3)), MW'($urandom)};
          default: b = {1'($urandom), EW'(60 + $urandom_range(0, 120)), MW'($urandom)};
        endcase
        in_a = a; in_b = b;
        in_valid = gaps ? 1'($urandom) : 1'b1;
        ev[c] = in_valid;
        ea[c] = model(a, b);
      end else in_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_same_sign();
    t_opp_sign();
    t_align();
    t_norm();
    t_zero();
    t_stream(1'b0);
    t_stream(1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule